// File: doc/BRIEF.md
# Signed Adder-Subtracter with Range and Sign Flags

This block is a combinational unit. It takes two signed words in two's complement form and either adds them or subtracts the second from the first. A single select input picks the operation. The block returns the n-bit result word and two status flags.

The core is a ripple chain of full adders, so the carry into the top bit and the carry out of the top bit are both available. When subtraction is selected, every bit of the second operand is inverted and the select itself becomes the carry into bit 0. The block never forms a separate negated operand.

Three flags are produced:
- The range flag says that the exact result does not fit in n signed bits. It comes from the two top carries.
- A second range flag is built only from the operand sign bits, the result sign bit and the final carry. It serves as a cross-check and must always match the first.
- The sign flag gives the sign of the exact result. It stays correct when the result word has wrapped.

Top module: `twos_addsub`

## Requirements
- R1: The result word equals the low n bits of op_a + (op_b XOR {n{sub_sel}}) + sub_sel, for both sub_sel = 0 (add) and sub_sel = 1 (subtract).
- R2: When the exact result lies in the signed range -2^(n-1) .. 2^(n-1)-1, the result word read as two's complement equals that exact result.
- R3: ovf_flag is 1 exactly when the exact sum or difference lies outside the n-bit signed range.
- R4: ovf_alt_flag, formed from the two operand sign bits, the result sign bit and the final carry, equals ovf_flag for every input.
- R5: neg_flag is 1 exactly when the exact result is below zero, including cases where the range flag is set.
- R6: neg_flag always equals ovf_flag XOR result[n-1].
- R7: Subtracting the most negative operand is handled correctly:
  - 0 minus the minimum gives result = minimum, ovf_flag = 1 and neg_flag = 0.
  - The minimum minus the minimum gives 0 with both flags at 0.
- R8: Wrap cases at the range ends are flagged:
  - The maximum plus 1 gives the minimum word, with ovf_flag = 1 and neg_flag = 0.
  - The minimum plus -1 gives the maximum word, with ovf_flag = 1 and neg_flag = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | WIDTH | First signed operand |
| op_b | input | WIDTH | Second signed operand |
| sub_sel | input | 1 | 0 selects add, 1 selects subtract |
| result | output | WIDTH | Low n bits of the sum or difference |
| ovf_flag | output | 1 | Out-of-range flag taken from the top two carries |
| ovf_alt_flag | output | 1 | Out-of-range flag taken from port-level bits only |
| neg_flag | output | 1 | Sign of the exact result |

## Verification
The range flag and the sign flag can both be set by the same operation. In that case the result word's top bit disagrees with the true sign.

The bench provokes this by sweeping every operand pair under both operations at widths 4 and 5. It also applies directed range-end operands. Each output is judged against an exact integer model computed at wider precision. The sign flag is checked against the exact sign and never against the result word.

// File: rtl/twos_addsub_pkg.sv
package twos_addsub_pkg;
    typedef struct packed {
        logic ovf;
        logic ovf_alt;
        logic neg;
    } flag_t;
endpackage

// File: rtl/tas_full_adder.sv
module tas_full_adder (
    input  logic bit_a,
    input  logic bit_b,
    input  logic carry_in,
    output logic sum_bit,
    output logic carry_out
);
    always_comb begin
        sum_bit   = bit_a ^ bit_b ^ carry_in;
        carry_out = (bit_a & bit_b) | (carry_in & (bit_a ^ bit_b));
    end
endmodule

// File: rtl/tas_ripple.sv
module tas_ripple #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] in_a,
    input  logic [WIDTH-1:0] in_b,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             carry_top_in,
    output logic             carry_out
);
    localparam int CW = WIDTH + 1;

    logic [CW-1:0] chain_d;

    assign chain_d[0] = cin;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        tas_full_adder u_fa (
            .bit_a     (in_a[i]),
            .bit_b     (in_b[i]),
            .carry_in  (chain_d[i]),
            .sum_bit   (sum[i]),
            .carry_out (chain_d[i+1])
        );
    end

    assign carry_top_in = chain_d[WIDTH-1];
    assign carry_out    = chain_d[WIDTH];

    // R1
    always_comb begin
        ripple_sum_chk: assert ({carry_out, sum} ==
            ({1'b0, in_a} + {1'b0, in_b} + {{WIDTH{1'b0}}, cin}))
            else $error("ripple chain disagrees with binary sum");
    end
endmodule

// File: rtl/tas_flags.sv
module tas_flags
    import twos_addsub_pkg::*;
(
    input  logic  a_top,
    input  logic  b_eff_top,
    input  logic  s_top,
    input  logic  c_top_in,
    input  logic  c_out,
    output flag_t flags_d
);
    always_comb begin
        flags_d.ovf     = c_top_in ^ c_out;
        flags_d.ovf_alt = a_top ^ b_eff_top ^ s_top ^ c_out;
        flags_d.neg     = a_top ^ b_eff_top ^ c_out;
    end

    // R4
    always_comb begin
        ovf_agree_chk: assert (flags_d.ovf == flags_d.ovf_alt)
            else $error("two overflow paths disagree");
    end

    // R6
    always_comb begin
        neg_relation_chk: assert (flags_d.neg == (flags_d.ovf ^ s_top))
            else $error("sign flag not ovf xor top result bit");
    end
endmodule

// File: rtl/twos_addsub.sv
module twos_addsub
    import twos_addsub_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic             sub_sel,
    output logic [WIDTH-1:0] result,
    output logic             ovf_flag,
    output logic             ovf_alt_flag,
    output logic             neg_flag
);
    localparam int TOP = WIDTH - 1;

    logic [WIDTH-1:0] b_eff_d;
    logic [WIDTH-1:0] sum_d;
    logic             c_top_in_d;
    logic             c_out_d;
    flag_t            flags_d;

    always_comb begin
        b_eff_d = op_b ^ {WIDTH{sub_sel}};
    end

    tas_ripple #(.WIDTH(WIDTH)) u_chain (
        .in_a         (op_a),
        .in_b         (b_eff_d),
        .cin          (sub_sel),
        .sum          (sum_d),
        .carry_top_in (c_top_in_d),
        .carry_out    (c_out_d)
    );

    tas_flags u_flags (
        .a_top     (op_a[TOP]),
        .b_eff_top (b_eff_d[TOP]),
        .s_top     (sum_d[TOP]),
        .c_top_in  (c_top_in_d),
        .c_out     (c_out_d),
        .flags_d   (flags_d)
    );

    always_comb begin
        result       = sum_d;
        ovf_flag     = flags_d.ovf;
        ovf_alt_flag = flags_d.ovf_alt;
        neg_flag     = flags_d.neg;
    end

    // R2
    always_comb begin
        no_overflow_chk: assert (ovf_flag || (neg_flag == result[TOP]))
            else $error("in-range result sign differs from sign flag");
    end

    initial begin
        width_min_chk: assert (WIDTH >= 2) else $error("WIDTH below 2");
    end
endmodule

// File: tb/twos_addsub_tb.sv
module twos_addsub_tb;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [4:0] a5, b5, r5;
    logic       s5, o5, oa5, n5;
    logic [3:0] a4, b4, r4;
    logic       s4, o4, oa4, n4;

    twos_addsub #(.WIDTH(5)) u_dut (
        .op_a(a5), .op_b(b5), .sub_sel(s5), .result(r5),
        .ovf_flag(o5), .ovf_alt_flag(oa5), .neg_flag(n5));

    twos_addsub #(.WIDTH(4)) u_dut4 (
        .op_a(a4), .op_b(b4), .sub_sel(s4), .result(r4),
        .ovf_flag(o4), .ovf_alt_flag(oa4), .neg_flag(n4));

    function automatic int sval(int raw, int n);
        return (raw >= (1 << (n-1))) ? raw - (1 << n) : raw;
    endfunction

    task automatic expect_eq(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic judge(int n, int a, int b, int sub, int res, int ovf, int ovfa, int neg);
        int m     = 1 << n;
        int exact = sub ? sval(a, n) - sval(b, n) : sval(a, n) + sval(b, n);
        int bits  = ((exact % m) + m) % m;
        int out_r = (exact < -(m/2)) || (exact > (m/2 - 1));
        int beff  = sub ? (~b & (m - 1)) : b;
        expect_eq("R1 result bits", res, (a + beff + sub) % m);
        if (!out_r) expect_eq("R2 in-range value", sval(res, n), exact);
        else        expect_eq("R2 wrapped bits", res, bits);
        expect_eq("R3 overflow", ovf, out_r);
        expect_eq("R4 alt overflow", ovfa, ovf);
        expect_eq("R5 sign", neg, exact < 0 ? 1 : 0);
        expect_eq("R6 sign relation", neg, ovf ^ ((res >> (n-1)) & 1));
    endtask

    task automatic run5(int a, int b, int sub);
        a5 = 5'(a); b5 = 5'(b); s5 = sub[0];
        #2;
        judge(5, a, b, sub, int'(r5), int'(o5), int'(oa5), int'(n5));
    endtask

    task automatic run4(int a, int b, int sub);
        a4 = 4'(a); b4 = 4'(b); s4 = sub[0];
        #2;
        judge(4, a, b, sub, int'(r4), int'(o4), int'(oa4), int'(n4));
    endtask

    task automatic t_zero;
        run5(0, 0, 0);
        expect_eq("R1 zero plus zero", int'(r5), 0);
    endtask

    task automatic t_sweep5;
        for (int s = 0; s < 2; s++)
            for (int a = 0; a < 32; a++)
                for (int b = 0; b < 32; b++) run5(a, b, s);
    endtask

    task automatic t_sweep4;
        for (int s = 0; s < 2; s++)
            for (int a = 0; a < 16; a++)
                for (int b = 0; b < 16; b++) run4(a, b, s);
    endtask

    task automatic t_corners;
        // min = 16 (-16), max = 15, -1 = 31 at width 5
        run5(16, 16, 1);
        expect_eq("R7 min-min result", int'(r5), 0);
        expect_eq("R7 min-min ovf", int'(o5), 0);
        expect_eq("R7 min-min neg", int'(n5), 0);
        run5(0, 16, 1);
        expect_eq("R7 0-min result", int'(r5), 16);
        expect_eq("R7 0-min ovf", int'(o5), 1);
        expect_eq("R7 0-min neg", int'(n5), 0);
        run5(15, 1, 0);
        expect_eq("R8 max+1 result", int'(r5), 16);
        expect_eq("R8 max+1 ovf", int'(o5), 1);
        expect_eq("R8 max+1 neg", int'(n5), 0);
        run5(16, 31, 0);
        expect_eq("R8 min-1 result", int'(r5), 15);
        expect_eq("R8 min-1 ovf", int'(o5), 1);
        expect_eq("R8 min-1 neg", int'(n5), 1);
        run4(0, 8, 1);
        expect_eq("R7 w4 0-min result", int'(r4), 8);
        expect_eq("R7 w4 0-min ovf", int'(o4), 1);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        a5 = '0; b5 = '0; s5 = 1'b0;
        a4 = '0; b4 = '0; s4 = 1'b0;
        @(negedge clk);
        t_zero;
        t_sweep5;
        t_sweep4;
        t_corners;
        finish_run;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run;
    end
endmodule